// File: doc/BRIEF.md
# Binary to Blanked Decimal Digit Converter

This block turns a 32-bit unsigned binary number into eight decimal digit codes for a multiplexed numeric display. Each code is five bits wide: a four-bit decimal digit and, above it, a flag that tells the display to leave that position dark. Codes come out least significant position first, so position 0 is the rightmost digit on the display.

A conversion starts with a one-cycle `start_i` pulse while the block is idle. The block samples the value and the padding mode on that edge. It then peels off one decimal digit per cycle: it takes the remainder by ten and divides the remaining value by ten. When the remaining value is zero, higher positions get either a dark code or a zero digit, depending on the mode. After the last position is done, the whole set of codes is copied to the output registers in one step, and `done_o` pulses for one cycle. The display driver reads `digits_o` whenever it likes, and the codes never show a half-finished result. Values of one hundred million and above keep only their lower eight decimal digits.

Top module: `bcd_blank_conv`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0 and every position of `digits_o` holds the dark code 5'h10.
- R2: A `start_i` high on a clock edge while `busy_o` is 0 is accepted. `busy_o` is 1 from the next cycle. `done_o` is high for exactly one cycle, and that cycle follows the ninth rising edge after the accepting edge.
- R3: Position i of `digits_o` is bits [5i+4:5i]. Position 0 is the least significant decimal digit. Bits [3:0] hold the digit and bit 4 is the dark flag.
- R4: While the value left after removing the lower positions is nonzero, the position's code is {1'b0, remainder mod 10}. A code with bit 4 clear never exceeds 9, and a code with bit 4 set has zero in its low bits.
- R5: With `zero_pad_i` = 0 at start, every position above the last significant digit gets 5'h10. An input of zero gives 5'h10 at all eight positions. A dark position is never followed by a lit position at a higher index.
- R6: With `zero_pad_i` = 1 at start, the positions that R5 would make dark get 5'h00 instead. No result in this mode has bit 4 set, and zero gives all 5'h00.
- R7: Inputs of 100000000 or more yield their value mod 100000000 as eight lit digits. For example, 100000000 gives all 5'h00 codes.
- R8: A `start_i` that arrives while `busy_o` is 1 has no effect. The running result is unchanged and no extra `done_o` follows.
- R9: `digits_o` changes only in the cycle in which `done_o` is 1. Changes on `value_i` and `zero_pad_i` after the accepting edge have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| start_i | input | 1 | Conversion request, sampled when idle |
| zero_pad_i | input | 1 | 1: show zeros above the top digit; 0: dark codes |
| value_i | input | 32 | Binary value to convert |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse when new codes appear |
| digits_o | output | 40 | Eight 5-bit codes, position 0 in bits [4:0] |

## Verification
The bench aims at the edges of the dark-code rule: zero in both modes, one-digit values, and exact powers of ten. A design that tested the current digit for zero instead of the remaining value would blank the inner zeros of 10 or 100000000. Inputs of 99999999, 100000000, 100000005 and the full 32-bit maximum probe truncation. A design that kept blanking above the eighth digit there, or that carried a ninth digit in, would show wrong high positions. A second start during a run and inputs that change in mid-run show whether the block restarts or re-samples, and this would appear as a corrupted result, an extra done pulse or codes that change while busy.

// File: rtl/bcd_blank_pkg.sv
package bcd_blank_pkg;
  localparam int unsigned CODE_W = 5;
  localparam logic [CODE_W-1:0] CODE_DARK = 5'h10;
  localparam logic [CODE_W-1:0] CODE_ZERO = 5'h00;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_LOAD = 2'd2
  } conv_state_e;
endpackage

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dec_div_step.sv
module dec_div_step #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] quo_o,
  output logic [3:0]   rem_o
);
  logic [W-1:0] rem_full;

  always_comb begin
    quo_o    = val_i / W'(10);
    rem_full = val_i % W'(10);
    rem_o    = rem_full[3:0];
  end
endmodule

// File: rtl/dec_digit_bank.sv
module dec_digit_bank
  import bcd_blank_pkg::*;
#(
  parameter int unsigned NDIG = 8,
  parameter int unsigned IW   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [IW-1:0]          wr_idx_i,
  input  logic [CODE_W-1:0]      wr_code_i,
  input  logic                   load_i,
  output logic [NDIG*CODE_W-1:0] digits_o
);
  logic [NDIG*CODE_W-1:0] stage_q, stage_d;
  logic [NDIG*CODE_W-1:0] out_q, out_d;

  for (genvar g = 0; g < NDIG; g++) begin : g_pos
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IW'(g));

    always_comb begin
      stage_d[g*CODE_W +: CODE_W] = stage_q[g*CODE_W +: CODE_W];
      if (hit) stage_d[g*CODE_W +: CODE_W] = wr_code_i;
      out_d[g*CODE_W +: CODE_W] = out_q[g*CODE_W +: CODE_W];
      if (load_i) out_d[g*CODE_W +: CODE_W] = stage_q[g*CODE_W +: CODE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[g*CODE_W +: CODE_W] <= CODE_DARK;
        out_q[g*CODE_W +: CODE_W]   <= CODE_DARK;
      end else begin
        stage_q[g*CODE_W +: CODE_W] <= stage_d[g*CODE_W +: CODE_W];
        out_q[g*CODE_W +: CODE_W]   <= out_d[g*CODE_W +: CODE_W];
      end
    end

    // a lit code is a decimal digit, a dark code carries no digit (R4)
    p_code_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_q[g*CODE_W+4] ? (out_q[g*CODE_W +: 4] == 4'd0)
                        : (out_q[g*CODE_W +: 4] <= 4'd9));

    if (g + 1 < NDIG) begin : g_order
      // once dark, every higher position is dark too (R5)
      p_dark_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_q[g*CODE_W+4] |-> out_q[(g+1)*CODE_W+4]);
    end
  end

  assign digits_o = out_q;
endmodule

// File: rtl/bcd_blank_conv.sv
module bcd_blank_conv
  import bcd_blank_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned NDIG = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   zero_pad_i,
  input  logic [W-1:0]           value_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [NDIG*CODE_W-1:0] digits_o
);
  localparam int unsigned IW = (NDIG > 1) ? $clog2(NDIG) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NDIG - 1);

  logic rst_ni;
  conv_state_e state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [W-1:0]  val_q, val_d;
  logic          pad_q, pad_d;
  logic          done_q, done_d;
  logic          wr_en, load;
  logic [W-1:0]  quo;
  logic [3:0]    rem;
  logic [CODE_W-1:0] wr_code;
  logic [NDIG-1:0]   dark_flags;

  rst_release_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_ni)
  );

  dec_div_step #(.W(W)) u_div (
    .val_i(val_q),
    .quo_o(quo),
    .rem_o(rem)
  );

  always_comb begin
    if (val_q != '0)  wr_code = {1'b0, rem};
    else if (pad_q)   wr_code = CODE_ZERO;
    else              wr_code = CODE_DARK;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    val_d   = val_q;
    pad_d   = pad_q;
    done_d  = 1'b0;
    wr_en   = 1'b0;
    load    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          idx_d   = '0;
          val_d   = value_i;
          pad_d   = zero_pad_i;
        end
      end
      ST_RUN: begin
        wr_en = 1'b1;
        val_d = quo;
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST_IDX) state_d = ST_LOAD;
      end
      ST_LOAD: begin
        load    = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      val_q   <= '0;
      pad_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      val_q   <= val_d;
      pad_q   <= pad_d;
      done_q  <= done_d;
    end
  end

  dec_digit_bank #(.NDIG(NDIG), .IW(IW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_ni),
    .wr_en_i  (wr_en),
    .wr_idx_i (idx_q),
    .wr_code_i(wr_code),
    .load_i   (load),
    .digits_o (digits_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  for (genvar g = 0; g < NDIG; g++) begin : g_flag
    assign dark_flags[g] = digits_o[g*CODE_W+4];
  end

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  p_busy_no_done_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_o && state_q == ST_RUN) |=> !done_o);

  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (digits_o != $past(digits_o)) |-> done_o);

  p_pad_lit_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o && pad_q) |-> (dark_flags == '0));
endmodule

// File: tb/bcd_blank_conv_bench.sv
module bcd_blank_conv_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        zero_pad_i = 1'b0;
  logic [31:0] value_i = '0;
  logic        busy_o, done_o;
  logic [39:0] digits_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bcd_blank_conv u_bcd_blank_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .zero_pad_i(zero_pad_i),
    .value_i   (value_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .digits_o  (digits_o)
  );

  function automatic logic [39:0] model(input logic [31:0] v, input logic pad);
    logic [39:0] r;
    logic [31:0] t;
    t = v;
    for (int i = 0; i < 8; i++) begin
      if (t != 0) begin
        r[5*i +: 5] = {1'b0, 4'(t % 10)};
        t = t / 10;
      end else begin
        r[5*i +: 5] = pad ? 5'h00 : 5'h10;
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  // one conversion with latency, busy, hold and sampling checks
  task automatic run_conv(input logic [31:0] v, input logic pad, input string req);
    logic [39:0] prev, exp;
    int n;
    bit held;
    prev = digits_o;
    exp  = model(v, pad);
    @(negedge clk);
    value_i = v; zero_pad_i = pad; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    value_i = $urandom; zero_pad_i = ~pad;          // R9: must be ignored
    check(busy_o === 1'b1, "R2 busy", 64'(busy_o), 64'd1);
    n = 0; held = 1'b1;
    while (done_o !== 1'b1 && n < 40) begin
      if (digits_o !== prev) held = 1'b0;
      @(negedge clk);
      n++;
    end
    check(n == 9, "R2 latency", 64'(n), 64'd9);
    check(held, "R9 hold while busy", 64'(digits_o), 64'(prev));
    check(digits_o === exp, req, 64'(digits_o), 64'(exp));
    @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0, "R2 single pulse", 64'({done_o, busy_o}), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] keep;
    logic [31:0] v;
    bit extra;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(busy_o === 1'b0 && done_o === 1'b0, "R1 flags", 64'({busy_o, done_o}), 64'd0);
    check(digits_o === {8{5'h10}}, "R1 codes", 64'(digits_o), 64'({8{5'h10}}));

    // R5 / R6 zero in both modes, literal expectations
    run_conv(32'd0, 1'b0, "R5 zero dark");
    check(digits_o === {8{5'h10}}, "R5 zero literal", 64'(digits_o), 64'({8{5'h10}}));
    run_conv(32'd0, 1'b1, "R6 zero padded");
    check(digits_o === 40'h0, "R6 zero literal", 64'(digits_o), 64'd0);
    // R3 position order: 7 in position 0
    run_conv(32'd7, 1'b0, "R3 single digit");
    check(digits_o[4:0] === 5'd7 && digits_o[9:5] === 5'h10, "R3 position 0",
          64'(digits_o[9:0]), 64'h207);
    run_conv(32'd10, 1'b0, "R4 inner zero");
    run_conv(32'd12345, 1'b1, "R6 padded");
    run_conv(32'd99999999, 1'b0, "R4 all nines");
    // R7 truncation
    run_conv(32'd100000000, 1'b0, "R7 exact 1e8");
    check(digits_o === 40'h0, "R7 literal", 64'(digits_o), 64'd0);
    run_conv(32'd100000005, 1'b0, "R7 1e8 plus 5");
    run_conv(32'hFFFFFFFF, 1'b0, "R7 max");

    // R8 start while busy
    @(negedge clk);
    value_i = 32'd4321; zero_pad_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    value_i = 32'd88888888; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (done_o !== 1'b1) @(negedge clk);
    check(digits_o === model(32'd4321, 1'b0), "R8 result kept",
          64'(digits_o), 64'(model(32'd4321, 1'b0)));
    keep = digits_o; extra = 1'b0;
    repeat (12) begin
      @(negedge clk);
      if (done_o === 1'b1 || digits_o !== keep) extra = 1'b1;
    end
    check(!extra, "R8 no extra done", 64'(digits_o), 64'(keep));

    // random mix of magnitudes
    for (int k = 0; k < 40; k++) begin
      v = $urandom >> ($urandom % 32);
      run_conv(v, 1'($urandom), "R4 random");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule